// File: doc/BRIEF.md
# Conditional Branch Resolver

This block works out where instruction fetch goes next on a 32-bit RISC core that numbers its bits big-endian. Each cycle it may receive one instruction word together with the 32-bit condition register. If the word is a branch, the block decides whether the branch is taken and writes the new program counter. It also updates the link register and the count register. All three of these registers live inside the block.

It handles four branch forms. The unconditional immediate form always jumps. The conditional immediate form, the conditional jump through the link register and the conditional jump through the count register all decide the same way. A 5-bit option field (BO) picks an optional count decrement-and-test and an optional test of one condition bit. A 5-bit index field (BI) names that condition bit. One shared datapath builds both the relative and the absolute targets, and also the link write.

A separate load port lets the surrounding core seed the three registers. Results are registered and appear one clock after the cycle that supplied the instruction.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted and right after it, `pc` equals the parameter `PC_RESET`, `lr` and `ctr` are zero, and `taken` and `illegal` are low.
- R2: When `ld_en` is high, `pc`, `lr` and `ctr` take `ld_pc`, `ld_lr` and `ld_ctr` at the next edge, `taken` and `illegal` are low, and any instruction presented in that cycle is ignored.
- R3: Primary opcode 16 (bits [31:26]) is the conditional immediate form. For it and for the link-register form, a BO value with bit 0x04 clear decrements `ctr` by one before the test. BO bit 0x02 then chooses the result: when 0 the count test passes on a nonzero count, and when 1 it passes on a zero count.
- R4: BO sits in bits [25:21] and BI in bits [20:16]. If BO bit 0x10 is set, the condition test is skipped. Otherwise it passes when bit `31-BI` of `cr` equals BO bit 0x08, so BI = 0 picks the most significant bit.
- R5: A conditional branch is taken only when both tests pass (or are skipped). BO = 0x14 always branches. Primary opcode 18 always branches.
- R6: Opcode 18 uses displacement bits [25:2] followed by two zeros, sign-extended from bit 25. Opcode 16 uses bits [15:2] followed by two zeros, sign-extended from bit 15. Instruction bit 1 set makes the displacement an absolute target; when it is clear the target is `pc` plus the displacement.
- R7: Primary opcode 19 with extended opcode 16 (bits [10:1]) jumps to the old `lr`, and with extended opcode 528 to `ctr`. In both cases the two low bits of the target are forced to zero. The link write never affects the target.
- R8: Instruction bit 0 set writes `pc`+4 into `lr` whether or not the branch is taken. A branch that is not taken goes on at `pc`+4.
- R9: The following words raise `illegal` one cycle later: the count-register form with BO bit 0x04 clear, any other primary opcode, and opcode 19 with any other extended opcode. Such a word leaves `pc`, `lr` and `ctr` unchanged and `taken` low.
- R10: A cycle with neither `valid` nor `ld_en` leaves all three registers unchanged, with `taken` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | `instr` holds a word to resolve this cycle |
| instr | input | 32 | Instruction word |
| cr | input | 32 | Condition register, bit 31 is condition bit 0 |
| ld_en | input | 1 | Load the three registers from the load port |
| ld_pc | input | 32 | Program counter to load |
| ld_lr | input | 32 | Link register to load |
| ld_ctr | input | 32 | Count register to load |
| taken | output | 1 | The previous cycle's branch was taken |
| illegal | output | 1 | The previous cycle's word was not a legal branch |
| pc | output | 32 | Program counter |
| lr | output | 32 | Link register |
| ctr | output | 32 | Count register |

## Verification
Each result is due exactly one rising edge after the cycle that presents the instruction or the load: the flags and all three registers change together at that edge, and nothing takes more than one cycle. The bench drives inputs on the falling edge. It lets one rising edge pass and compares every output on the next falling edge against a behavioural model that it advanced for that same cycle. No result is ever read early or late. Runs of back-to-back count branches verify that each cycle decrements from the count the previous cycle left behind.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter logic [31:0] PC_RESET = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [31:0] instr,
  input  logic [31:0] cr,
  input  logic        ld_en,
  input  logic [31:0] ld_pc,
  input  logic [31:0] ld_lr,
  input  logic [31:0] ld_ctr,
  output logic        taken,
  output logic        illegal,
  output logic [31:0] pc,
  output logic [31:0] lr,
  output logic [31:0] ctr
);

  localparam logic [5:0] OP_BC   = 6'd16;
  localparam logic [5:0] OP_B    = 6'd18;
  localparam logic [5:0] OP_XL   = 6'd19;
  localparam logic [9:0] XO_LR   = 10'd16;
  localparam logic [9:0] XO_CTR  = 10'd528;

  wire [5:0] opc  = instr[31:26];
  wire [4:0] bo   = instr[25:21];
  wire [4:0] bi   = instr[20:16];
  wire [9:0] xo   = instr[10:1];
  wire       abs_a = instr[1];
  wire       link  = instr[0];

  wire f_uncond = opc == OP_B;
  wire f_cimm   = opc == OP_BC;
  wire f_tolr   = opc == OP_XL && xo == XO_LR;
  wire f_toctr  = opc == OP_XL && xo == XO_CTR;

  wire bad = !(f_uncond || f_cimm || f_tolr || f_toctr) || (f_toctr && !bo[2]);

  wire        dec     = !f_uncond && !bo[2];
  wire [31:0] ctr_nx  = dec ? ctr - 32'd1 : ctr;
  wire        ctr_ok  = bo[2] || ((ctr_nx != 32'd0) ^ bo[1]);
  wire        cr_sel  = cr[5'd31 - bi];
  wire        cr_ok   = bo[4] || (cr_sel == bo[3]);
  wire        go      = f_uncond || (ctr_ok && cr_ok);

  wire [31:0] disp_l = {{6{instr[25]}}, instr[25:2], 2'b00};
  wire [31:0] disp_s = {{16{instr[15]}}, instr[15:2], 2'b00};
  wire [31:0] disp   = f_uncond ? disp_l : disp_s;
  wire [31:0] seq    = pc + 32'd4;

  logic [31:0] target;
  always_comb begin
    if (f_tolr)       target = {lr[31:2], 2'b00};
    else if (f_toctr) target = {ctr[31:2], 2'b00};
    else if (abs_a)   target = disp;
    else              target = pc + disp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= PC_RESET;
      lr      <= '0;
      ctr     <= '0;
      taken   <= 1'b0;
      illegal <= 1'b0;
    end else if (ld_en) begin
      pc      <= ld_pc;
      lr      <= ld_lr;
      ctr     <= ld_ctr;
      taken   <= 1'b0;
      illegal <= 1'b0;
    end else if (valid && bad) begin
      taken   <= 1'b0;
      illegal <= 1'b1;
    end else if (valid) begin
      pc      <= go ? target : seq;
      lr      <= link ? seq : lr;
      ctr     <= ctr_nx;
      taken   <= go;
      illegal <= 1'b0;
    end else begin
      taken   <= 1'b0;
      illegal <= 1'b0;
    end
  end

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic [31:0] instr,
  input logic        ld_en,
  input logic [31:0] ld_pc,
  input logic        taken,
  input logic        illegal,
  input logic [31:0] pc,
  input logic [31:0] lr,
  input logic [31:0] ctr
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken && illegal)); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (pc == $past(ld_pc) && !taken && !illegal)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !ld_en) |=> ($stable(pc) && $stable(lr) && $stable(ctr) && !taken && !illegal)); // R10

  AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(pc) && $stable(lr) && $stable(ctr))); // R9

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ld_en) |=> (taken || illegal || pc == $past(pc) + 32'd4)); // R8

  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ld_en && instr[0]) |=> (illegal || lr == $past(pc) + 32'd4)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ld_en) |=> (ctr == $past(ctr) || ctr == $past(ctr) - 32'd1)); // R3

endmodule

bind branch_unit branch_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr), .ld_en(ld_en),
  .ld_pc(ld_pc), .taken(taken), .illegal(illegal), .pc(pc), .lr(lr), .ctr(ctr)
);

// File: tb/sim_branch_unit.sv
module sim_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] cr = '0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_pc = '0, ld_lr = '0, ld_ctr = '0;
  logic        taken, illegal;
  logic [31:0] pc, lr, ctr;

  localparam logic [31:0] RST_PC = 32'h0000_0100;

  branch_unit #(.PC_RESET(RST_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr), .cr(cr),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_lr(ld_lr), .ld_ctr(ld_ctr),
    .taken(taken), .illegal(illegal), .pc(pc), .lr(lr), .ctr(ctr)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit done = 0;
  longint m_pc, m_lr, m_ctr;

  function automatic logic [31:0] enc_b(input int words, input bit aa, input bit lk);
    logic [23:0] li = 24'(words);
    return {6'd18, li, aa, lk};
  endfunction
  function automatic logic [31:0] enc_bc(input int bo, input int bi, input int words,
                                         input bit aa, input bit lk);
    logic [13:0] bd = 14'(words);
    return {6'd16, 5'(bo), 5'(bi), bd, aa, lk};
  endfunction
  function automatic logic [31:0] enc_xl(input int bo, input int xo, input bit lk);
    return {6'd19, 5'(bo), 5'd0, 5'd0, 10'(xo), lk};
  endfunction

  task automatic compare(input string tag, input bit et, input bit ei);
    n_run++;
    if (taken !== et || illegal !== ei || pc !== 32'(m_pc) || lr !== 32'(m_lr) || ctr !== 32'(m_ctr)) begin
      n_bad++;
      $display("FAIL %s: got t=%0b i=%0b pc=%h lr=%h ctr=%h exp t=%0b i=%0b pc=%h lr=%h ctr=%h",
               tag, taken, illegal, pc, lr, ctr, et, ei, 32'(m_pc), 32'(m_lr), 32'(m_ctr));
    end
  endtask

  task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] crv,
                      input bit le, input logic [31:0] lp, input logic [31:0] ll,
                      input logic [31:0] lc, input string tag);
    bit et = 0, ei = 0;
    int kind;
    valid = v; instr = ins; cr = crv; ld_en = le; ld_pc = lp; ld_lr = ll; ld_ctr = lc;
    if (le) begin
      m_pc = lp; m_lr = ll; m_ctr = lc;
    end else if (v) begin
      int op = ins[31:26];
      int xo = ins[10:1];
      int bo = ins[25:21];
      int bi = ins[20:16];
      kind = -1;
      if (op == 18) kind = 0;
      else if (op == 16) kind = 1;
      else if (op == 19 && xo == 16) kind = 2;
      else if (op == 19 && xo == 528) kind = 3;
      if (kind < 0 || (kind == 3 && (bo & 4) == 0)) ei = 1;
      else begin
        longint c = m_ctr;
        bit cpass, rpass;
        longint tgt;
        if (kind != 0 && (bo & 4) == 0) c = (c + 32'hFFFF_FFFF) % 64'h1_0000_0000;
        if (bo & 4) cpass = 1;
        else if (bo & 2) cpass = (c == 0);
        else cpass = (c != 0);
        if (bo & 16) rpass = 1;
        else rpass = (crv[31 - bi] == ((bo & 8) != 0));
        et = (kind == 0) || (cpass && rpass);
        case (kind)
          0: tgt = longint'($signed({ins[25:2], 2'b00}));
          1: tgt = longint'($signed({ins[15:2], 2'b00}));
          2: tgt = m_lr - (m_lr % 4);
          default: tgt = m_ctr - (m_ctr % 4);
        endcase
        if (kind < 2 && !ins[1]) tgt = tgt + m_pc;
        tgt = tgt & 64'hFFFF_FFFF;
        if (ins[0]) m_lr = (m_pc + 4) % 64'h1_0000_0000;
        m_pc = et ? tgt : (m_pc + 4) % 64'h1_0000_0000;
        m_ctr = c;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag, et, ei);
  endtask

  task automatic idle(input string tag);
    step(0, 32'hFFFF_FFFF, '1, 0, '0, '0, '0, tag);
  endtask
  task automatic load(input logic [31:0] p, input logic [31:0] l, input logic [31:0] c, input string tag);
    step(0, '0, '0, 1, p, l, c, tag);
  endtask
  task automatic br(input logic [31:0] ins, input logic [31:0] crv, input string tag);
    step(1, ins, crv, 0, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    m_pc = RST_PC; m_lr = 0; m_ctr = 0;
    compare("R1 reset", 0, 0);
    rst_n = 1'b1;
    idle("R10 idle after reset");
    load(32'h1000, 32'h2004, 32'd3, "R2 load");
    step(1, enc_b(64, 0, 0), '0, 1, 32'h4000, 32'h3003, 32'd3, "R2 load beats instr");
    br(enc_b(64, 0, 0), '0, "R6 b rel forward");
    br(enc_b(-16, 0, 0), '0, "R6 b rel backward");
    br(enc_b(32'h80, 1, 1), '0, "R6 R8 b absolute link");
    br(enc_b(-8, 1, 0), '0, "R6 b absolute negative");
    load(32'h1000, 32'h3003, 32'd3, "R2 reload");
    br(enc_bc(20, 7, 8, 0, 0), '0, "R5 bc always");
    br(enc_bc(12, 0, 4, 0, 0), 32'h8000_0000, "R4 cr bit0 true taken");
    br(enc_bc(12, 0, 4, 0, 0), 32'h7FFF_FFFF, "R4 cr bit0 true not taken");
    br(enc_bc(4, 5, -4, 0, 0), 32'hFBFF_FFFF, "R4 cr bit5 false taken");
    br(enc_bc(4, 5, -4, 0, 1), 32'h0400_0000, "R4 R8 not taken link");
    br(enc_bc(16, 0, 2, 0, 0), '0, "R3 dnz 3->2 taken");
    br(enc_bc(16, 0, 2, 0, 0), '0, "R3 dnz 2->1 taken");
    br(enc_bc(16, 0, 2, 0, 0), '0, "R3 dnz 1->0 not taken");
    br(enc_bc(18, 0, 2, 1, 0), '0, "R3 dz wraps not taken");
    load(32'h2000, 32'h3003, 32'd1, "R2 reload ctr1");
    br(enc_bc(18, 0, 6, 0, 0), '0, "R3 dz 1->0 taken");
    load(32'h2000, 32'h3003, 32'd2, "R2 reload ctr2");
    br(enc_bc(0, 31, 6, 0, 0), 32'h0000_0001, "R5 ctr ok cr fails");
    br(enc_bc(0, 31, 6, 0, 0), 32'h0000_0000, "R5 ctr fails cr ok");
    load(32'h2000, 32'h3003, 32'd5, "R2 reload ctr5");
    br(enc_bc(8, 31, 6, 0, 0), 32'h0000_0001, "R5 both pass");
    br(enc_xl(20, 16, 1), '0, "R7 R8 bclr link old lr");
    br(enc_xl(20, 16, 0), '0, "R7 bclr to new lr");
    load(32'h2000, 32'h3003, 32'h5006, "R2 reload ctr");
    br(enc_xl(20, 528, 0), '0, "R7 bcctr aligned");
    br(enc_xl(4, 528, 1), 32'h0, "R7 bcctr cr false");
    br(enc_xl(16, 528, 1), '0, "R9 bcctr decrement illegal");
    br({6'd31, 26'h0}, '0, "R9 unknown opcode");
    br(enc_xl(20, 150, 0), '0, "R9 unknown extended op");
    br(enc_xl(16, 16, 0), '0, "R3 bclr decrement");
    idle("R10 idle hold");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule